// File: doc/BRIEF.md
# Per-CPU Level Interrupt Mask Controller

This block gathers a configurable number of level-sensitive interrupt lines, organised as 32-bit words, and gives every CPU its own register bank on a simple single-cycle register bus. Each bank has a private mask and drives a private interrupt line to its CPU. A source reaches a CPU only while its input is high and that CPU's bank leaves it unmasked. Software can therefore steer any source to exactly one CPU by unmasking it in that bank alone.

Software reads the live input levels and reads back its mask. It changes the mask only through two write-only registers. Writing ones to the first register disables the selected sources. Writing ones to the second register enables them. No read-modify-write is needed, and zero bits never disturb other bits. The register groups are packed back to back, so every offset scales with the word count.

Top module: `lic_top`

## Requirements
- R1: With NUM_WORDS = N (1 to 8), a read of byte offset 4*w inside a bank (w < N) returns the live level of sources 32*w to 32*w+31. Bit i of the data is source 32*w+i. Address bits [1:0] are ignored.
- R2: A read of offset 4*(N+w) inside a bank returns that bank's mask word w. A 1 means the source is disabled.
- R3: A write to offset 4*(2N+w) sets the mask bits that are 1 in the write data. All other mask bits of that bank are unchanged.
- R4: A write to offset 4*(3N+w) clears the mask bits that are 1 in the write data. All other mask bits of that bank are unchanged.
- R5: After reset every mask bit of every bank is 1, every CPU interrupt output is 0 and no read response is pending.
- R6: cpu_irq[k] is 1 exactly one clock after a cycle in which some source is high while bank k's mask bit for that source is 0.
- R7: A write addressed to bank k never changes the mask of any other bank. The same source may be enabled in one bank and disabled in the others.
- R8: Writes to the status and mask-readback offsets change nothing. Reads of the set and clear offsets return 0.
- R9: A read returns its data on bus_rdata with bus_rvalid high one clock after the request. In cycles without a read response, bus_rdata is 0.
- R10: An access at or above byte address NUM_CPUS*16*N reads as 0 and its writes change no mask.
- R11: Bank k starts at byte address k*16*N, and every offset above is relative to that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32*NUM_WORDS | Level-sensitive interrupt inputs |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| cpu_irq | output | NUM_CPUS | Interrupt line per CPU bank |

## Verification
Read data and cpu_irq both come from one register stage. A read issued in cycle t is due at the clock edge that closes cycle t. An input level or mask change that is present in cycle t shows on cpu_irq at that same edge. A mask write takes effect at its edge, so the interrupt line reflects it one edge later. The bench keeps a behavioural model that is updated at every rising edge from the inputs and the model state before that edge. It compares the model with every output at the following falling edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        GRP_LEVEL = 2'd0,
        GRP_MASKRD = 2'd1,
        GRP_SET = 2'd2,
        GRP_CLR = 2'd3
    } lic_grp_e;

endpackage

// File: rtl/lic_decode.sv
module lic_decode
    import lic_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 2,
    parameter int unsigned NUM_CPUS = 2,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned BANK_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int unsigned WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank_idx,
    output lic_grp_e          grp,
    output logic [WORD_W-1:0] word_idx
);

    localparam logic [ADDR_W-1:0] WORDS_PER_BANK = ADDR_W'(4 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] WORDS_PER_GRP = ADDR_W'(NUM_WORDS);
    localparam logic [ADDR_W-1:0] BANK_LIMIT = ADDR_W'(NUM_CPUS);

    logic [ADDR_W-1:0] widx;
    logic [ADDR_W-1:0] bank_full;
    logic [ADDR_W-1:0] rem_full;
    logic [ADDR_W-1:0] grp_full;
    logic [ADDR_W-1:0] word_full;

    always_comb begin
        widx = addr >> 2;
        bank_full = widx / WORDS_PER_BANK;
        rem_full = widx % WORDS_PER_BANK;
        grp_full = rem_full / WORDS_PER_GRP;
        word_full = rem_full % WORDS_PER_GRP;
        hit = (bank_full < BANK_LIMIT);
        bank_idx = BANK_W'(bank_full);
        grp = lic_grp_e'(2'(grp_full));
        word_idx = WORD_W'(word_full);
    end

endmodule

// File: rtl/lic_bank.sv
module lic_bank
    import lic_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 2,
    localparam int unsigned WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned SRC_W = DATA_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  lic_grp_e          grp,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_W-1:0]  src,
    output logic [SRC_W-1:0]  mask_bits,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] mask;
        logic                             irq;
    } bank_state_t;

    localparam bank_state_t RESET_STATE = '{mask: '1, irq: 1'b0};

    bank_state_t st_d;
    bank_state_t st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (wr_en && (word_idx == WORD_W'(w))) begin
                if (grp == GRP_SET) begin
                    st_d.mask[w] = st_q.mask[w] | wdata;
                end else if (grp == GRP_CLR) begin
                    st_d.mask[w] = st_q.mask[w] & ~wdata;
                end
            end
        end
        st_d.irq = |(src & ~SRC_W'(st_q.mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_bits = st_q.mask;
    assign irq = st_q.irq;

    for (genvar gw = 0; gw < NUM_WORDS; gw++) begin : g_word_chk
        assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && grp == GRP_SET && word_idx == WORD_W'(gw))
            |=> ((st_q.mask[gw] & $past(wdata)) == $past(wdata)));

        assert_clr_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && grp == GRP_CLR && word_idx == WORD_W'(gw))
            |=> ((st_q.mask[gw] & $past(wdata)) == '0));
    end

    assert_idle_mask_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || grp == GRP_LEVEL || grp == GRP_MASKRD) |=> $stable(st_q.mask));

    assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |=> !irq);

endmodule

// File: rtl/lic_top.sv
module lic_top
    import lic_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 2,
    parameter int unsigned NUM_CPUS = 2,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned SRC_W = DATA_W * NUM_WORDS,
    localparam int unsigned BANK_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int unsigned WORD_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_W-1:0]    irq_src,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [NUM_CPUS-1:0] cpu_irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rsp_state_t;

    logic              hit;
    logic [BANK_W-1:0] bank_idx;
    lic_grp_e          grp;
    logic [WORD_W-1:0] word_idx;

    logic [NUM_CPUS-1:0][SRC_W-1:0] mask_all;
    logic [SRC_W-1:0]               mask_sel;
    logic [DATA_W-1:0]              mask_word;
    logic [DATA_W-1:0]              level_word;

    rsp_state_t rsp_d;
    rsp_state_t rsp_q;

    lic_decode #(
        .NUM_WORDS(NUM_WORDS),
        .NUM_CPUS (NUM_CPUS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr    (bus_addr),
        .hit     (hit),
        .bank_idx(bank_idx),
        .grp     (grp),
        .word_idx(word_idx)
    );

    for (genvar gk = 0; gk < NUM_CPUS; gk++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_valid && bus_write && hit && (bank_idx == BANK_W'(gk));

        lic_bank #(
            .NUM_WORDS(NUM_WORDS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .grp      (grp),
            .word_idx (word_idx),
            .wdata    (bus_wdata),
            .src      (irq_src),
            .mask_bits(mask_all[gk]),
            .irq      (cpu_irq[gk])
        );

        assert_other_banks_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && !(hit && bank_idx == BANK_W'(gk)))
            |=> $stable(mask_all[gk]));
    end

    always_comb begin
        mask_sel = '0;
        for (int k = 0; k < NUM_CPUS; k++) begin
            if (bank_idx == BANK_W'(k)) begin
                mask_sel = mask_all[k];
            end
        end
        mask_word = '0;
        level_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_idx == WORD_W'(w)) begin
                mask_word = mask_sel[w*DATA_W +: DATA_W];
                level_word = irq_src[w*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        rsp_d = '0;
        if (bus_valid && !bus_write) begin
            rsp_d.rvalid = 1'b1;
            if (hit) begin
                case (grp)
                    GRP_LEVEL: rsp_d.rdata = level_word;
                    GRP_MASKRD: rsp_d.rdata = mask_word;
                    default: rsp_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata = rsp_q.rdata;
    assign bus_rvalid = rsp_q.rvalid;

    assert_rvalid_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

    assert_oob_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !hit) |=> (bus_rdata == '0));

    assert_wo_regs_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && hit && (grp == GRP_SET || grp == GRP_CLR))
        |=> (bus_rdata == '0));

endmodule

// File: tb/lic_top_bench.sv
module lic_top_bench;

    localparam int NW = 3;
    localparam int NC = 3;
    localparam int AW = 12;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [32*NW-1:0]  irq_src = '0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NC-1:0]     cpu_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_live = 1'b0;
    bit done = 1'b0;

    logic [31:0]   m_mask [NC][NW];
    logic [31:0]   exp_rdata = '0;
    logic          exp_rvalid = 1'b0;
    logic [NC-1:0] exp_irq = '0;
    string         exp_tag = "R9";

    lic_top #(
        .NUM_WORDS(NW),
        .NUM_CPUS (NC),
        .ADDR_W   (AW)
    ) u_lic_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .cpu_irq   (cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int reg_addr(int bank, int grp, int w);
        return 4 * (bank * 4 * NW + grp * NW + w);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural model, advanced at each rising edge from pre-edge state.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NC; k++)
                for (int w = 0; w < NW; w++)
                    m_mask[k][w] = 32'hFFFF_FFFF;
            exp_rdata = '0;
            exp_rvalid = 1'b0;
            exp_irq = '0;
            model_live = 1'b1;
        end else begin
            int a, wi, bank, rem, g, w;
            for (int k = 0; k < NC; k++) begin
                logic any;
                any = 1'b0;
                for (int j = 0; j < NW; j++)
                    if ((irq_src[j*32 +: 32] & ~m_mask[k][j]) != 0) any = 1'b1;
                exp_irq[k] = any;
            end
            exp_rvalid = bus_valid && !bus_write;
            exp_rdata = '0;
            exp_tag = "R9";
            if (bus_valid) begin
                a = int'(bus_addr);
                wi = a / 4;
                bank = wi / (4 * NW);
                rem = wi % (4 * NW);
                g = rem / NW;
                w = rem % NW;
                if (bank >= NC) begin
                    exp_tag = "R10";
                end else if (!bus_write) begin
                    case (g)
                        0: begin exp_rdata = irq_src[w*32 +: 32]; exp_tag = (bank > 0) ? "R11" : "R1"; end
                        1: begin exp_rdata = m_mask[bank][w]; exp_tag = "R2"; end
                        default: begin exp_rdata = '0; exp_tag = "R8"; end
                    endcase
                end else begin
                    if (g == 2) m_mask[bank][w] = m_mask[bank][w] | bus_wdata;
                    else if (g == 3) m_mask[bank][w] = m_mask[bank][w] & ~bus_wdata;
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && model_live && !done) begin
            check(bus_rvalid == exp_rvalid, {exp_tag, " rvalid"}, 32'(bus_rvalid), 32'(exp_rvalid));
            check(bus_rdata == exp_rdata, {exp_tag, " rdata"}, bus_rdata, exp_rdata);
            check(cpu_irq == exp_irq, "R6 R7 cpu_irq", 32'(cpu_irq), 32'(exp_irq));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic access(bit wr, int addr, logic [31:0] data);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr = AW'(addr);
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: outputs quiet while held in reset
        check(cpu_irq == '0, "R5 cpu_irq in reset", 32'(cpu_irq), 32'h0);
        check(bus_rvalid == 1'b0, "R5 rvalid in reset", 32'(bus_rvalid), 32'h0);
        rst_n = 1'b1;
        irq_src = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
        @(negedge clk);
        // R5: every mask word reads back as all ones
        for (int k = 0; k < NC; k++)
            for (int w = 0; w < NW; w++)
                access(1'b0, reg_addr(k, 1, w), '0);
        @(negedge clk);
        check(cpu_irq == '0, "R5 all masked with inputs high", 32'(cpu_irq), 32'h0);

        // R1 R11: live levels visible in every bank
        irq_src = {32'h1234_5678, 32'hDEAD_BEEF, 32'hA5A5_0F0F};
        for (int k = 0; k < NC; k++)
            for (int w = 0; w < NW; w++)
                access(1'b0, reg_addr(k, 0, w), '0);

        // R4: clear some bits of bank 0 word 1, then R2 readback
        access(1'b1, reg_addr(0, 3, 1), 32'h0000_00F0);
        access(1'b0, reg_addr(0, 1, 1), '0);
        // R3: set part of them back
        access(1'b1, reg_addr(0, 2, 1), 32'h0000_0030);
        access(1'b0, reg_addr(0, 1, 1), '0);

        // R6 R7: steer source 5 to CPU 1 only
        irq_src = '0;
        access(1'b1, reg_addr(0, 2, 1), 32'hFFFF_FFFF);
        access(1'b1, reg_addr(1, 3, 0), 32'h0000_0020);
        repeat (2) @(negedge clk);
        irq_src[5] = 1'b1;
        repeat (2) @(negedge clk);
        check(cpu_irq == 3'b010, "R7 steered interrupt", 32'(cpu_irq), 32'h2);
        irq_src[5] = 1'b0;
        repeat (2) @(negedge clk);
        check(cpu_irq == 3'b000, "R6 level drop", 32'(cpu_irq), 32'h0);

        // R8: writes to level and readback offsets ignored, write-only offsets read zero
        access(1'b1, reg_addr(2, 0, 0), 32'h0000_0000);
        access(1'b1, reg_addr(2, 1, 2), 32'h0000_0000);
        access(1'b0, reg_addr(2, 1, 2), '0);
        access(1'b0, reg_addr(2, 2, 0), '0);
        access(1'b0, reg_addr(2, 3, 2), '0);

        // R10: beyond the last bank
        access(1'b1, NC * 16 * NW + 4 * (3 * NW), 32'hFFFF_FFFF);
        access(1'b0, NC * 16 * NW, '0);
        access(1'b0, 4092, '0);
        access(1'b1, 4092, 32'hFFFF_FFFF);
        for (int k = 0; k < NC; k++)
            access(1'b0, reg_addr(k, 1, NW - 1), '0);

        // Mixed traffic with changing levels
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 4) == 0)
                irq_src = {$urandom, $urandom, $urandom};
            if (($urandom % 3) == 0) begin
                @(negedge clk);
            end else begin
                int range;
                range = (($urandom % 8) == 0) ? 4096 : NC * 16 * NW;
                access(1'b1 & $urandom, int'($urandom % range), $urandom);
            end
        end
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule